// File: doc/BRIEF.md
# SPI Byte-Stream Engine for Fixed-Size Command Packets

This block sits behind a byte-wide packet source on the device side of a host link. Bytes arrive with a valid/ready handshake and are grouped into fixed packets of 32 bytes. The first byte of each packet is a command and the other 31 are its payload. A streaming command sends each payload byte out on a serial clock and data lines, least-significant bit first. At the same time it collects one byte from the input lines, and each collected byte leaves on a reply stream that also uses valid/ready.

A configuration command carries a small stream of sub-commands. One sub-command sets a 3-bit mode code. Bit 2 of that code picks dual-line transfers: two bits go out and two come in per clock. The lower two bits are a bus-rate selection that this block only holds and presents on an output. Chip select is handled elsewhere. The serial clock idles low. Output bits are set up while the clock is low, and input bits are sampled at the rising edge. The serial clock period is `DIV` system clocks.

Top module: `spi_pkt_engine`

## Requirements
- R1: After reset, sclk is 0, sdo is 2'b11, replyValid is 0, inReady is 1, rateSel is 0 and dualMode is 0.
- R2: Accepted bytes are counted in groups of 32. Position 0 of each group is decoded as a command, and positions 1..31 are never decoded as commands, whatever their value.
- R3: When the command byte is 8'hA8, each of the 31 following bytes is shifted out and exactly one reply byte is produced per shifted byte. In single mode, each step sends one bit on sdo[1] (bit 0 first), sdo[0] is held at 1, sdi[1] is sampled and assembled into the reply from bit 0 upward, and a byte takes 8 clock steps.
- R4: In dual mode a byte takes 4 steps. Step k sends bit 2k on sdo[1] and bit 2k+1 on sdo[0], and it reads reply bit 2k from sdi[1] and bit 2k+1 from sdi[0].
- R5: When the command byte is 8'hAA, a later byte of the form 8'b01100xyz in that packet latches the code xyz. Bits yz appear on rateSel and x on dualMode. Bits of this code change only at such a byte.
- R6: Inside an 8'hAA packet, a byte of 8'h00 ends the configuration stream. Later bytes of that packet change nothing, and other non-matching bytes before the end are ignored.
- R7: Any other command value causes the rest of its packet to be accepted and dropped, with no sclk pulse, no reply byte and no configuration change.
- R8: sclk is low whenever no byte is being shifted. Within a byte, rising edges are DIV system clocks apart and each high phase lasts DIV - DIV/2 system clocks.
- R9: While a byte is shifting, or while its finished reply waits for a full reply slot to drain, inReady is 0, so a new byte is accepted only once the previous one is fully on the wire. replyValid and replyData hold steady while replyReady is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Packet byte is offered |
| inData | input | 8 | Packet byte |
| inReady | output | 1 | Engine can take a byte this cycle |
| replyValid | output | 1 | Reply byte is offered |
| replyData | output | 8 | Reply byte collected from the input lines |
| replyReady | input | 1 | Consumer takes the reply byte |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 2 | Serial data out; [1] is the primary line, [0] the second line |
| sdi | input | 2 | Serial data in; [1] is the primary line, [0] the second line |
| rateSel | output | 2 | Latched bus-rate selection |
| dualMode | output | 1 | Latched dual-line selection |

## Verification
The case that needs the most care is the end of a shifted byte landing in the same cycle that the reply slot is still held by a stalled consumer. In that case the engine has to park the finished byte, keep inReady low and leave the waiting reply untouched. The bench provokes this by dropping replyReady at random during the dual-line and final single-line packets, while a slave model keeps serving reply bits. On every clock it checks that a stalled reply stays unchanged, that no new payload byte is taken before the previous one has fully left on the wire, and that every reply popped matches the slave's byte in order.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;

  localparam logic [7:0] CMD_STREAM = 8'hA8;
  localparam logic [7:0] CMD_CONFIG = 8'hAA;
  localparam logic [4:0] CFG_SET_TAG = 5'b01100;
  localparam logic [7:0] CFG_END = 8'h00;

  typedef enum logic [1:0] {
    PM_STREAM,
    PM_CONFIG,
    PM_DROP
  } pkt_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD
  } shift_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       dual;
    logic [7:0] data;
  } shift_req_t;

endpackage

// File: rtl/spi_pkt_ctrl.sv
module spi_pkt_ctrl
  import spi_pkt_pkg::*;
#(
  parameter int PKT_BYTES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       dpIdle,
  output logic       inReady,
  output shift_req_t req,
  output logic [1:0] rateSel,
  output logic       dualMode
);

  localparam int IDX_W = $clog2(PKT_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

  logic [IDX_W-1:0] pktIdx;
  pkt_mode_t        mode;
  logic [2:0]       cfgCode;
  logic             accept;
  logic             atCmd;

  always_comb begin
    inReady = dpIdle;
    accept  = inValid && dpIdle;
    atCmd   = (pktIdx == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pktIdx  <= '0;
      mode    <= PM_DROP;
      cfgCode <= 3'b000;
    end else if (accept) begin
      pktIdx <= (pktIdx == LAST_IDX) ? '0 : pktIdx + 1'b1;
      if (atCmd) begin
        if (inData == CMD_STREAM)      mode <= PM_STREAM;
        else if (inData == CMD_CONFIG) mode <= PM_CONFIG;
        else                           mode <= PM_DROP;
      end else if (mode == PM_CONFIG) begin
        if (inData[7:3] == CFG_SET_TAG) cfgCode <= inData[2:0];
        else if (inData == CFG_END)     mode <= PM_DROP;
      end
    end
  end

  always_comb begin
    req.load = accept && !atCmd && (mode == PM_STREAM);
    req.dual = cfgCode[2];
    req.data = inData;
    rateSel  = cfgCode[1:0];
    dualMode = cfgCode[2];
  end

  // R5: the code moves only after a set byte inside a configuration packet
  p_cfg_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfgCode) |-> $past(accept && !atCmd && mode == PM_CONFIG
                                && inData[7:3] == CFG_SET_TAG));

endmodule

// File: rtl/spi_pkt_datapath.sv
module spi_pkt_datapath
  import spi_pkt_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  shift_req_t req,
  input  logic [1:0] sdi,
  input  logic       replyReady,
  output logic       sclk,
  output logic [1:0] sdo,
  output logic       replyValid,
  output logic [7:0] replyData,
  output logic       idle
);

  localparam int HALF  = DIV / 2;
  localparam int CNT_W = $clog2(DIV);
  localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] FALL_AT = CNT_W'(DIV - 1);

  shift_state_t   state;
  logic [CNT_W-1:0] divCnt;
  logic [2:0]     stepCnt;
  logic [7:0]     txSh;
  logic [7:0]     rxSh;
  logic [7:0]     rxNext;
  logic           dualNow;
  logic           sclkQ;
  logic           replyValidQ;
  logic [7:0]     replyDataQ;
  logic           lastStep;
  logic           replyFree;
  logic           deposit;

  always_comb begin
    lastStep  = (stepCnt == (dualNow ? 3'd3 : 3'd7));
    replyFree = !replyValidQ || replyReady;
    deposit   = (state == ST_SHIFT && divCnt == FALL_AT && lastStep && replyFree)
             || (state == ST_HOLD && replyReady);
    rxNext    = dualNow ? {sdi[0], sdi[1], rxSh[7:2]} : {sdi[1], rxSh[7:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      stepCnt <= 3'd0;
      txSh    <= 8'h00;
      rxSh    <= 8'h00;
      dualNow <= 1'b0;
      sclkQ   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req.load) begin
            txSh    <= req.data;
            rxSh    <= 8'h00;
            dualNow <= req.dual;
            divCnt  <= '0;
            stepCnt <= 3'd0;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (divCnt == FALL_AT) begin
            sclkQ  <= 1'b0;
            divCnt <= '0;
            if (lastStep) begin
              state <= replyFree ? ST_IDLE : ST_HOLD;
            end else begin
              txSh    <= dualNow ? {2'b00, txSh[7:2]} : {1'b0, txSh[7:1]};
              stepCnt <= stepCnt + 3'd1;
            end
          end else begin
            if (divCnt == RISE_AT) begin
              sclkQ <= 1'b1;
              rxSh  <= rxNext;
            end
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (replyReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      replyValidQ <= 1'b0;
      replyDataQ  <= 8'h00;
    end else if (deposit) begin
      replyValidQ <= 1'b1;
      replyDataQ  <= rxSh;
    end else if (replyReady) begin
      replyValidQ <= 1'b0;
    end
  end

  always_comb begin
    if (state == ST_SHIFT) sdo = dualNow ? {txSh[0], txSh[1]} : {txSh[0], 1'b1};
    else                   sdo = 2'b11;
    sclk       = sclkQ;
    replyValid = replyValidQ;
    replyData  = replyDataQ;
    idle       = (state == ST_IDLE);
  end

  // R9: a stalled reply keeps its value
  p_reply_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    replyValidQ && !replyReady |=> replyValidQ && $stable(replyDataQ));

  // R9: control only loads a byte when the shifter is free
  p_load_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req.load |-> state == ST_IDLE);

  // R8: serial clock rests low outside a shift
  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_SHIFT |-> !sclkQ);

  // R3: a new reply appears only at the end of a shifted byte
  p_reply_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(replyValidQ) |-> $past(state == ST_SHIFT || state == ST_HOLD));

endmodule

// File: rtl/spi_pkt_engine.sv
module spi_pkt_engine
  import spi_pkt_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int PKT_BYTES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       inReady,
  output logic       replyValid,
  output logic [7:0] replyData,
  input  logic       replyReady,
  output logic       sclk,
  output logic [1:0] sdo,
  input  logic [1:0] sdi,
  output logic [1:0] rateSel,
  output logic       dualMode
);

  shift_req_t req;
  logic       dpIdle;

  spi_pkt_ctrl #(.PKT_BYTES(PKT_BYTES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inData   (inData),
    .dpIdle   (dpIdle),
    .inReady  (inReady),
    .req      (req),
    .rateSel  (rateSel),
    .dualMode (dualMode)
  );

  spi_pkt_datapath #(.DIV(DIV)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .sdi        (sdi),
    .replyReady (replyReady),
    .sclk       (sclk),
    .sdo        (sdo),
    .replyValid (replyValid),
    .replyData  (replyData),
    .idle       (dpIdle)
  );

endmodule

// File: tb/spi_pkt_engine_test.sv
module spi_pkt_engine_test;
  localparam int DIV    = 4;
  localparam int HIGH_W = DIV - DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inReady;
  logic replyValid;
  logic [7:0] replyData;
  logic replyReady = 1'b1;
  logic sclk;
  logic [1:0] sdo;
  logic [1:0] sdi = 2'b00;
  logic [1:0] rateSel;
  logic dualMode;

  always #5 clk = ~clk;

  spi_pkt_engine #(.DIV(DIV), .PKT_BYTES(32)) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData), .inReady(inReady),
    .replyValid(replyValid), .replyData(replyData), .replyReady(replyReady),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .rateSel(rateSel), .dualMode(dualMode)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] respByte(input int i);
    return 8'((i * 73 + 29) ^ (i >> 2));
  endfunction

  // reference model state
  bit expDual = 0;
  bit stallMode = 0;
  string wireTag = "R3";
  logic [7:0] wireExpQ[$];
  logic [7:0] wireAcc = 8'h00;
  logic [7:0] prevData = 8'h00;
  bit prevSclk = 0;
  bit prevStall = 0;
  int slaveStep = 0, slaveIdx = 0, replyCnt = 0, riseCnt = 0;
  int lastRise = 0, highRun = 0, cycle = 0, acceptedSpi = 0;
  logic [7:0] pkt[32];

  always @(negedge clk) begin
    logic [7:0] r;
    cycle++;
    if (rst_n) begin
      if (sclk && !prevSclk) begin
        riseCnt++;
        if (slaveStep != 0)
          check(cycle - lastRise == DIV, "R8 rise spacing", cycle - lastRise, DIV);
        lastRise = cycle;
        if (expDual) begin
          wireAcc[2*slaveStep]   = sdo[1];
          wireAcc[2*slaveStep+1] = sdo[0];
        end else begin
          wireAcc[slaveStep] = sdo[1];
          check(sdo[0] == 1'b1, "R3 second line idle", int'(sdo[0]), 1);
        end
        slaveStep++;
        if (slaveStep == (expDual ? 4 : 8)) begin
          if (wireExpQ.size() == 0)
            check(0, "R3 unexpected wire byte", int'(wireAcc), 0);
          else begin
            logic [7:0] e;
            e = wireExpQ.pop_front();
            check(wireAcc == e, {wireTag, " wire byte"}, int'(wireAcc), int'(e));
          end
          slaveStep = 0;
          slaveIdx++;
        end
      end
      if (sclk) highRun++;
      else if (prevSclk) begin
        check(highRun == HIGH_W, "R8 high width", highRun, HIGH_W);
        highRun = 0;
      end
      prevSclk = sclk;
      if (prevStall)
        check(replyValid && replyData == prevData, "R9 reply hold", int'(replyData), int'(prevData));
      replyReady = stallMode ? (($urandom % 4) == 0) : 1'b1;
      prevStall = replyValid && !replyReady;
      prevData = replyData;
      if (replyValid && replyReady) begin
        check(replyData == respByte(replyCnt), expDual ? "R4 reply byte" : "R3 reply byte",
              int'(replyData), int'(respByte(replyCnt)));
        replyCnt++;
      end
    end
    r = respByte(slaveIdx);
    if (expDual) sdi = {r[2*slaveStep], r[2*slaveStep+1]};
    else         sdi = {r[slaveStep], 1'b0};
  end

  task automatic sendByte(input logic [7:0] b, input bit isSpi);
    @(negedge clk); #1;
    while (!inReady) begin @(negedge clk); #1; end
    inValid = 1'b1;
    inData = b;
    if (isSpi) begin
      check(acceptedSpi == slaveIdx, "R9 accept after wire done", acceptedSpi, slaveIdx);
      wireExpQ.push_back(b);
      acceptedSpi++;
    end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic sendPacket();
    sendByte(pkt[0], 1'b0);
    for (int i = 1; i < 32; i++) sendByte(pkt[i], pkt[0] == 8'hA8);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int snapRise, snapReply;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk); #1;
    check(sclk == 0 && sdo == 2'b11, "R1 reset lines", {sclk, sdo}, 3'b011);
    check(!replyValid && inReady, "R1 reset handshake", {replyValid, inReady}, 2'b01);
    check(rateSel == 0 && !dualMode, "R1 reset config", {dualMode, rateSel}, 0);

    // single-line stream, consumer always ready
    pkt[0] = 8'hA8;
    for (int i = 1; i < 32; i++) pkt[i] = 8'(i * 17 + 3);
    sendPacket();

    // config: set rate 2 dual, end, then a set byte that must be ignored
    pkt[0] = 8'hAA; pkt[1] = 8'h66; pkt[2] = 8'h00; pkt[3] = 8'h61;
    for (int i = 4; i < 32; i++) pkt[i] = 8'h65;
    sendPacket();
    repeat (3) @(negedge clk);
    check(rateSel == 2'd2, "R6 rate after end", rateSel, 2);
    check(dualMode == 1'b1, "R5 dual latched", dualMode, 1);
    expDual = 1;
    stallMode = 1;
    wireTag = "R4";

    pkt[0] = 8'hA8;
    for (int i = 1; i < 32; i++) pkt[i] = 8'(i * 29 + 8'h5C);
    sendPacket();
    while (replyCnt != acceptedSpi) @(negedge clk);

    // unknown command
    snapRise = riseCnt;
    snapReply = replyCnt;
    pkt[0] = 8'h3C;
    for (int i = 1; i < 32; i++) pkt[i] = (i % 2) ? 8'h65 : 8'hA8;
    sendPacket();
    repeat (40) @(negedge clk);
    check(riseCnt == snapRise, "R7 no sclk", riseCnt, snapRise);
    check(replyCnt == snapReply && !replyValid, "R7 no reply", replyCnt, snapReply);
    check(rateSel == 2'd2 && dualMode, "R7 config kept", {dualMode, rateSel}, 3'b110);

    // config: set rate 3 single, non-matching byte ignored, end, later set ignored
    pkt[0] = 8'hAA; pkt[1] = 8'h63; pkt[2] = 8'h7F; pkt[3] = 8'h00; pkt[4] = 8'h67;
    for (int i = 5; i < 32; i++) pkt[i] = 8'h00;
    sendPacket();
    repeat (3) @(negedge clk);
    check(rateSel == 2'd3, "R5 rate latched", rateSel, 3);
    check(dualMode == 1'b0, "R6 single after end", dualMode, 0);
    expDual = 0;
    wireTag = "R2";

    // payload holding command-like values, consumer stalls
    pkt[0] = 8'hA8;
    for (int i = 1; i < 32; i++) pkt[i] = (i % 3 == 0) ? 8'hAA : ((i % 3 == 1) ? 8'hA8 : 8'(i * 7));
    sendPacket();
    while (replyCnt != acceptedSpi) @(negedge clk);
    stallMode = 0;
    repeat (4) @(negedge clk);
    check(replyCnt == 93, "R3 reply count", replyCnt, 93);
    check(wireExpQ.size() == 0, "R3 wire queue empty", wireExpQ.size(), 0);
    check(sclk == 0 && inReady, "R8 idle after run", {sclk, inReady}, 2'b01);
    done = 1;
    summary();
    $finish;
  end
endmodule